// File: doc/BRIEF.md
# Processor Wait-State Controller

This block sits between an 8-bit processor and a slow part of its memory map. On every rising edge of the processor clock it looks at the top address bit and a bus-valid qualifier. An access to the upper half of memory raises a wait-request flag. The processor's active-high ready input is driven as the inverse of that flag, so the processor stalls. The flag stays up until the slow side signals completion by pulling its active-low ready line low. That line is sampled on a rising clock edge. There is no timeout, so a slow device may take as many cycles as it needs.

The block also drives the enable of the external data buffer. In normal cycles the buffer is enabled only while the clock is high. This leaves the clock-low half free as a dead time for handing the bus between drivers. During a write that is waiting, the buffer stays enabled through both clock phases, so a slow device sees stable write data for the whole access. Reset is synchronous.

Top module: `wait_state_ctrl`

## Requirements
- R1: On a rising edge with `bus_valid` high, `addr_hi` high and no wait in progress, `wait_req` goes high after that edge. The level of `slow_rdy_n` has no effect on this start.
- R2: While idle, an edge with `addr_hi` low or `bus_valid` low leaves `wait_req` low. The low half of memory never causes a wait.
- R3: `cpu_ready` is always the inverse of `wait_req`.
- R4: While waiting, `slow_rdy_n` sampled low (0 = done) on a rising edge clears `wait_req` after that edge. A low pulse on `slow_rdy_n` that falls between two edges has no effect.
- R5: While waiting, each edge with `slow_rdy_n` high keeps `wait_req` high, with no limit on the number of cycles. `cpu_ready` is therefore low for exactly the number of edges the slow side withholds ready.
- R6: If the bus still presents a slow access on the edge right after a completion, `wait_req` rises again on that edge.
- R7: During a wait started by a write (`rd_nwr` = 0 at the start edge), `buf_en` is high in both the clock-high and the clock-low phases.
- R8: Outside write waits, `buf_en` is high only while `clk` is high and `bus_valid` is high. It is low in every clock-low phase, including the low phases of read waits.
- R9: A synchronous `rst` high on an edge clears `wait_req`. While `rst` is high, `buf_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; high phase is the data phase |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Address bus holds a valid access |
| addr_hi | input | 1 | Top address bit; 1 selects the slow region |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| slow_rdy_n | input | 1 | Completion from the slow side, active low, level sampled |
| wait_req | output | 1 | Wait-request flag |
| cpu_ready | output | 1 | Ready to the processor, active high |
| buf_en | output | 1 | External data buffer enable, active high |

## Verification
The hardest case to reach is completion followed at once by a new slow access. In that case the flag must drop for a single cycle and rise again. The bench produces it by keeping the slow address on the bus through the completing edge. A second hard case is a ready pulse from the slow side that starts and ends between two clock edges. The bench produces it by pulsing `slow_rdy_n` inside the clock period. A modelled responder with random latency checks that `cpu_ready` is low for exactly the edges on which ready was withheld. During write waits, the bench also samples `buf_en` in the clock-low phase.

// File: rtl/wait_state_ctrl.sv
module wait_state_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic bus_valid,
  input  logic addr_hi,
  input  logic rd_nwr,
  input  logic slow_rdy_n,
  output logic wait_req,
  output logic cpu_ready,
  output logic buf_en
);

  logic waiting;
  logic wr_hold;
  logic slow_start;

  assign slow_start = bus_valid & addr_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= 1'b0;
      wr_hold <= 1'b0;
    end else if (waiting) begin
      waiting <= slow_rdy_n;
    end else if (slow_start) begin
      waiting <= 1'b1;
      wr_hold <= ~rd_nwr;
    end
  end

  assign wait_req  = waiting;
  assign cpu_ready = ~waiting;
  assign buf_en    = ~rst & ((clk & bus_valid) | (waiting & wr_hold));

  // R1
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (!wait_req && bus_valid && addr_hi) |=> wait_req);

  // R2
  low_half_chk: assert property (@(posedge clk) disable iff (rst)
    (!wait_req && !(bus_valid && addr_hi)) |=> !wait_req);

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_req && !slow_rdy_n) |=> !wait_req);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_req && slow_rdy_n) |=> (wait_req && !cpu_ready));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !wait_req);

endmodule

// File: tb/tb_wait_state_ctrl.sv
module tb_wait_state_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, bus_valid, addr_hi, rd_nwr, slow_rdy_n;
  logic wait_req, cpu_ready, buf_en;
  int compared = 0;
  int mismatched = 0;

  always #(CLK_P/2) clk = ~clk;

  wait_state_ctrl dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .addr_hi(addr_hi),
    .rd_nwr(rd_nwr), .slow_rdy_n(slow_rdy_n),
    .wait_req(wait_req), .cpu_ready(cpu_ready), .buf_en(buf_en)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // moves to 1 time unit after the next rising edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1; bus_valid = 0; addr_hi = 0; rd_nwr = 1; slow_rdy_n = 1;
    step();
    step();
    #2;
    check("R9 wait_req", wait_req, 1'b0);
    check("R9 cpu_ready", cpu_ready, 1'b1);
    bus_valid = 1;
    #0;
    check("R9 buf_en", buf_en, 1'b0);
    @(negedge clk);
    bus_valid = 0;
    step();
    rst = 0;
    step();
    check("R9 idle after reset", wait_req, 1'b0);
  endtask

  task automatic t_low_half();
    bus_valid = 1; addr_hi = 0; rd_nwr = 0; slow_rdy_n = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R2 low half", wait_req, 1'b0);
      check("R3 ready", cpu_ready, 1'b1);
      #2;
      check("R8 high phase", buf_en, 1'b1);
      #4;
      check("R8 low phase", buf_en, 1'b0);
    end
    bus_valid = 0; addr_hi = 1; slow_rdy_n = 1;
    step();
    check("R2 not valid", wait_req, 1'b0);
    #2;
    check("R8 not valid", buf_en, 1'b0);
  endtask

  // one slow access with given latency; keep_slow leaves the bus on a slow access
  task automatic t_slow(input logic is_write, input int lat, input logic keep_slow);
    int low_cnt;
    low_cnt = 0;
    bus_valid = 1; addr_hi = 1; rd_nwr = ~is_write; slow_rdy_n = 0;
    step();
    check("R1 start", wait_req, 1'b1);
    slow_rdy_n = 1;
    for (int i = 0; i < lat; i++) begin
      if (cpu_ready == 1'b0) low_cnt++;
      check("R3 inverse", cpu_ready, ~wait_req);
      #2;
      check(is_write ? "R7 high phase" : "R8 read high", buf_en, 1'b1);
      #4;
      check(is_write ? "R7 low phase" : "R8 read low", buf_en, is_write);
      if (i == lat - 1) slow_rdy_n = 0;
      step();
      if (i < lat - 1) check("R5 hold", wait_req, 1'b1);
    end
    check("R5 exact wait count", low_cnt == lat, 1'b1);
    check("R4 clear", wait_req, 1'b0);
    check("R3 ready back", cpu_ready, 1'b1);
    slow_rdy_n = 1;
    if (keep_slow) begin
      step();
      check("R6 back to back", wait_req, 1'b1);
      slow_rdy_n = 0;
      step();
      check("R4 clear second", wait_req, 1'b0);
      slow_rdy_n = 1;
    end
    bus_valid = 0; addr_hi = 0;
    step();
    check("R2 idle", wait_req, 1'b0);
  endtask

  task automatic t_glitch();
    bus_valid = 1; addr_hi = 1; rd_nwr = 1; slow_rdy_n = 1;
    step();
    check("R1 start", wait_req, 1'b1);
    #1; slow_rdy_n = 0;
    #2; slow_rdy_n = 1;
    step();
    check("R4 pulse between edges ignored", wait_req, 1'b1);
    slow_rdy_n = 0;
    step();
    check("R4 clear", wait_req, 1'b0);
    slow_rdy_n = 1; bus_valid = 0; addr_hi = 0;
    step();
  endtask

  task automatic t_reset_mid_wait();
    bus_valid = 1; addr_hi = 1; rd_nwr = 0; slow_rdy_n = 1;
    step();
    check("R1 start", wait_req, 1'b1);
    bus_valid = 0; addr_hi = 0;
    rst = 1;
    step();
    check("R9 mid wait", wait_req, 1'b0);
    #6;
    check("R9 buf_en low", buf_en, 1'b0);
    rst = 0;
    step();
  endtask

  initial begin
    #(CLK_P * 200000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    t_reset();
    t_low_half();
    t_slow(1'b1, 1, 1'b0);
    t_slow(1'b0, 3, 1'b0);
    t_slow(1'b1, 5, 1'b1);
    for (int k = 0; k < 6; k++) begin
      int lat;
      lat = 1 + ($urandom(seed + k) % 12);
      t_slow(k[0], lat, k[1]);
    end
    t_slow(1'b0, 40, 1'b0);
    t_glitch();
    t_reset_mid_wait();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule